// File: doc/BRIEF.md
# Five-Stage In-Order Integer Core

This block is a 32-bit in-order processor core built as a five-stage pipeline. The stages are instruction fetch, decode with register read, execute or address calculation, data memory access, and register write-back. Each stage takes one clock cycle, and registers separate the stages. The core holds a 32-entry register file. It executes a fixed set of ten instructions in three encodings: register-register, register-immediate and jump.

The core drives two word-addressed memory ports, one for instructions and one for data. Both are expected to behave as synchronous arrays that return read data one clock after the address is presented. Addresses count 32-bit words, so the program counter advances by one for each instruction. The core has no hazard detection and no forwarding. Software must place at least two unrelated instructions between a producer and its consumer. The all-zero word serves as the no-operation.

Top module: `pipe5_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and empties the pipeline. While reset is held, `imem_addr` is 0 and `dmem_we` is 0.
- R2: Outside reset and jumps, `imem_addr` rises by exactly 1 every clock. It is a word index.
- R3: Opcode bits [31:26] = 0x00 with shift bits [10:6] = 0 select a register operation on rs [25:21] and rt [20:16], written to rd [15:11]. Function bits [5:0] select it: 0x20 add, 0x22 subtract (rs-rt), 0x24 and, 0x25 or, 0x27 nor, 0x2A signed set-less-than (1 or 0).
- R4: Opcode 0x08 writes rs plus the sign-extended 16-bit immediate [15:0] into rt.
- R5: Opcode 0x2B stores rt at word address rs + sign-extended immediate. `dmem_we` is high for exactly one cycle, with `dmem_addr` and `dmem_wdata` valid in that cycle.
- R6: Opcode 0x23 loads the word at rs + sign-extended immediate into rt. Read data is taken one cycle after the address is presented.
- R7: Instruction k (counted from reset release) drives its store onto the data port in cycle k+3. A register result is visible to an instruction issued three slots later, because a write-back and a read of the same register in one cycle return the new value.
- R8: Register 0 reads as zero. Writes to it, including one in flight during a same-cycle read, have no effect.
- R9: Opcode 0x02 jumps to {upper six PC bits, bits [25:0]}, resolved in decode. The single instruction fetched behind the jump is discarded, and the fetch address equals the target in the cycle that follows.
- R10: Any other opcode, any other function code, and register encodings with nonzero bits [10:6] write no register and store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction word address (program counter) |
| imem_rdata | input | 32 | Instruction word, valid one cycle after the address |
| dmem_addr | output | 32 | Data word address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | 32 | Load data, valid one cycle after the address |

## Verification
The bench places a consumer exactly three slots after its producer. A register file without the same-cycle write-to-read path would hand that consumer a stale value. It places store instructions in the slot right behind a jump and beyond it. A core that did not discard the slot behind the jump, or that discarded too many, would leave a wrong word in data memory. Register 0 is written while it is being read, to catch a bypass that forgets the zero register. Negative immediates and an unsupported function code cover sign-extension and decode errors. Each of these shows up as a wrong or extra store in data memory.

// File: rtl/p5_pkg.sv
package p5_pkg;
  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_JUMP  = 6'h02;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_NOR = 6'h27;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_wr;
    logic    mem_rd;
    logic    mem_wr;
    logic    use_imm;
    logic    jump;
    alu_op_e alu;
  } ctrl_t;
endpackage

// File: rtl/p5_alu.sv
module p5_alu
  import p5_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_NOR: y = ~(a | b);
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/p5_decode.sv
module p5_decode
  import p5_pkg::*;
(
  input  logic       valid,
  input  logic [5:0] opc,
  input  logic [5:0] funct,
  input  logic [4:0] rt,
  input  logic [4:0] rd,
  input  logic [4:0] shamt,
  output ctrl_t      ctrl,
  output logic [4:0] dst
);
  always_comb begin
    ctrl = '{reg_wr: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0,
             use_imm: 1'b0, jump: 1'b0, alu: ALU_ADD};
    dst  = rt;
    if (valid) begin
      unique case (opc)
        OPC_REG: begin
          dst = rd;
          if (shamt == 5'd0) begin
            ctrl.reg_wr = 1'b1;
            unique case (funct)
              FN_ADD:  ctrl.alu = ALU_ADD;
              FN_SUB:  ctrl.alu = ALU_SUB;
              FN_AND:  ctrl.alu = ALU_AND;
              FN_OR:   ctrl.alu = ALU_OR;
              FN_NOR:  ctrl.alu = ALU_NOR;
              FN_SLT:  ctrl.alu = ALU_SLT;
              default: ctrl.reg_wr = 1'b0;
            endcase
          end
        end
        OPC_ADDI: begin
          ctrl.reg_wr  = 1'b1;
          ctrl.use_imm = 1'b1;
        end
        OPC_LOAD: begin
          ctrl.reg_wr  = 1'b1;
          ctrl.mem_rd  = 1'b1;
          ctrl.use_imm = 1'b1;
        end
        OPC_STORE: begin
          ctrl.mem_wr  = 1'b1;
          ctrl.use_imm = 1'b1;
        end
        OPC_JUMP: ctrl.jump = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/p5_regfile.sv
module p5_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [N];
  logic         wr_ok;

  assign wr_ok = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_ok) regs[waddr] <= wdata;
  end

  always_comb begin
    if (raddr_a == '0)                  rdata_a = '0;
    else if (wr_ok && waddr == raddr_a) rdata_a = wdata;
    else                                rdata_a = regs[raddr_a];
    if (raddr_b == '0)                  rdata_b = '0;
    else if (wr_ok && waddr == raddr_b) rdata_b = wdata;
    else                                rdata_b = regs[raddr_b];
  end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import p5_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam int RIDX = $clog2(NREGS);
  localparam int JBITS = 26;
  localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

  // Fetch: the memory's registered output acts as the fetch/decode register
  logic [XLEN-1:0]       pc;
  logic [XLEN-1:JBITS]   id_pc_hi;
  logic                  id_valid;
  logic                  jmp_taken;
  logic [XLEN-1:0]       jmp_target;

  // Decode
  ctrl_t                 id_ctrl;
  logic [4:0]            id_dst;
  logic [RIDX-1:0]       rs_idx, rt_idx;
  logic [XLEN-1:0]       rs_val, rt_val, id_imm;

  // Execute
  logic                  ex_rw, ex_ld, ex_st, ex_use_imm;
  alu_op_e               ex_alu;
  logic [XLEN-1:0]       ex_a, ex_b, ex_imm, ex_y;
  logic [RIDX-1:0]       ex_dst;

  // Memory
  logic                  mem_rw, mem_ld;
  logic [XLEN-1:0]       mem_res, mem_wdata;
  logic [RIDX-1:0]       mem_dst;

  // Write-back
  logic                  wb_rw, wb_ld;
  logic [XLEN-1:0]       wb_res, wb_data;
  logic [RIDX-1:0]       wb_dst;

  assign jmp_taken  = id_ctrl.jump;
  assign jmp_target = {id_pc_hi, imem_rdata[JBITS-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      id_valid <= 1'b0;
    end else begin
      pc       <= jmp_taken ? jmp_target : pc + ONE;
      id_valid <= ~jmp_taken;
    end
    id_pc_hi <= pc[XLEN-1:JBITS];
  end

  p5_decode u_dec (
    .valid (id_valid),
    .opc   (imem_rdata[31:26]),
    .funct (imem_rdata[5:0]),
    .rt    (imem_rdata[20:16]),
    .rd    (imem_rdata[15:11]),
    .shamt (imem_rdata[10:6]),
    .ctrl  (id_ctrl),
    .dst   (id_dst)
  );

  assign rs_idx = imem_rdata[21 +: RIDX];
  assign rt_idx = imem_rdata[16 +: RIDX];
  assign id_imm = {{(XLEN-16){imem_rdata[15]}}, imem_rdata[15:0]};

  p5_regfile #(.W(XLEN), .N(NREGS)) u_rf (
    .clk     (clk),
    .we      (wb_rw),
    .waddr   (wb_dst),
    .wdata   (wb_data),
    .raddr_a (rs_idx),
    .raddr_b (rt_idx),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_rw <= 1'b0;
      ex_ld <= 1'b0;
      ex_st <= 1'b0;
    end else begin
      ex_rw <= id_ctrl.reg_wr;
      ex_ld <= id_ctrl.mem_rd;
      ex_st <= id_ctrl.mem_wr;
    end
    ex_use_imm <= id_ctrl.use_imm;
    ex_alu     <= id_ctrl.alu;
    ex_a       <= rs_val;
    ex_b       <= rt_val;
    ex_imm     <= id_imm;
    ex_dst     <= id_dst[RIDX-1:0];
  end

  p5_alu #(.W(XLEN)) u_alu (
    .a  (ex_a),
    .b  (ex_use_imm ? ex_imm : ex_b),
    .op (ex_alu),
    .y  (ex_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rw  <= 1'b0;
      mem_ld  <= 1'b0;
      dmem_we <= 1'b0;
    end else begin
      mem_rw  <= ex_rw;
      mem_ld  <= ex_ld;
      dmem_we <= ex_st;
    end
    mem_res   <= ex_y;
    mem_wdata <= ex_b;
    mem_dst   <= ex_dst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_rw <= 1'b0;
      wb_ld <= 1'b0;
    end else begin
      wb_rw <= mem_rw;
      wb_ld <= mem_ld;
    end
    wb_res <= mem_res;
    wb_dst <= mem_dst;
  end

  assign wb_data    = wb_ld ? dmem_rdata : wb_res;
  assign imem_addr  = pc;
  assign dmem_addr  = mem_res;
  assign dmem_wdata = mem_wdata;
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk #(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] imem_addr,
  input logic            dmem_we,
  input logic            jmp_taken,
  input logic [XLEN-1:0] jmp_target,
  input logic            id_valid,
  input logic [RIDX-1:0] rs_idx,
  input logic [XLEN-1:0] rs_val
);
  p_reset_pc_r1: assert property (@(posedge clk) rst |=> imem_addr == '0);
  p_reset_nostore_r1: assert property (@(posedge clk) rst |=> !dmem_we);
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    !jmp_taken |=> imem_addr == $past(imem_addr) + 1);
  p_jump_target_r9: assert property (@(posedge clk) disable iff (rst)
    jmp_taken |=> imem_addr == $past(jmp_target));
  p_jump_squash_r9: assert property (@(posedge clk) disable iff (rst)
    jmp_taken |=> !id_valid);
  p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
    (rs_idx == '0) |-> (rs_val == '0));
endmodule

bind pipe5_core pipe5_core_chk #(.XLEN(XLEN), .RIDX(RIDX)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .imem_addr  (imem_addr),
  .dmem_we    (dmem_we),
  .jmp_taken  (jmp_taken),
  .jmp_target (jmp_target),
  .id_valid   (id_valid),
  .rs_idx     (rs_idx),
  .rs_val     (rs_val)
);

// File: tb/pipe5_core_bench.sv
`timescale 1ns/1ps
module pipe5_core_bench;
  localparam int MW = 64;
  localparam logic [31:0] FILL = 32'hA5A5_A5A5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [31:0] imem [MW];
  logic [31:0] dmem [MW];

  int n_checks = 0;
  int n_fails  = 0;
  int store_cnt;
  int first_store;
  logic [31:0] addr_at [MW];

  always #4 clk = ~clk;

  pipe5_core u_pipe5_core (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  always @(posedge clk) begin
    imem_rdata <= imem[imem_addr[5:0]];
    dmem_rdata <= dmem[dmem_addr[5:0]];
    if (dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;
  end

  function automatic logic [31:0] op_r(input logic [5:0] fn, input int rd, rs, rt);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] op_i(input logic [5:0] opc, input int rt, rs, imm);
    return {opc, rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] op_j(input int tgt);
    return {6'h02, tgt[25:0]};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_mems();
    for (int i = 0; i < MW; i++) begin
      imem[i] = 32'h0;
      dmem[i] = FILL;
    end
  endtask

  task automatic run(input int cycles);
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    store_cnt   = 0;
    first_store = -1;
    addr_at[0]  = imem_addr;
    for (int i = 1; i <= cycles; i++) begin
      @(negedge clk);
      if (i < MW) addr_at[i] = imem_addr;
      if (dmem_we) begin
        store_cnt++;
        if (first_store < 0) first_store = i;
      end
    end
  endtask

  task automatic t_reset();
    clear_mems();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "pc in reset", imem_addr, 32'd0);
    chk("R1", "store strobe in reset", {31'd0, dmem_we}, 32'd0);
    run(5);
    chk("R2", "pc after 1 clock", addr_at[1], 32'd1);
    chk("R2", "pc after 5 clocks", addr_at[5], 32'd5);
    chk("R1", "no stores from empty pipe", store_cnt, 0);
  endtask

  task automatic t_alu();
    clear_mems();
    imem[0]  = op_i(6'h08, 1, 0, 5);
    imem[1]  = op_i(6'h08, 2, 0, -3);
    imem[4]  = op_r(6'h20, 3, 1, 2);
    imem[5]  = op_r(6'h22, 4, 1, 2);
    imem[6]  = op_r(6'h24, 5, 1, 2);
    imem[7]  = op_r(6'h25, 6, 1, 2);
    imem[8]  = op_r(6'h27, 7, 1, 2);
    imem[9]  = op_r(6'h2A, 8, 2, 1);
    imem[10] = op_r(6'h2A, 9, 1, 2);
    for (int k = 0; k < 7; k++) imem[13+k] = op_i(6'h2B, 3+k, 0, 10+k);
    run(30);
    chk("R4", "addi negative imm via add", dmem[10], 32'd2);
    chk("R3", "sub", dmem[11], 32'd8);
    chk("R3", "and", dmem[12], 32'd5);
    chk("R3", "or", dmem[13], 32'hFFFF_FFFD);
    chk("R3", "nor", dmem[14], 32'd2);
    chk("R3", "slt signed true", dmem[15], 32'd1);
    chk("R3", "slt signed false", dmem[16], 32'd0);
  endtask

  task automatic t_mem();
    clear_mems();
    imem[0]  = op_i(6'h08, 1, 0, 20);
    imem[1]  = op_i(6'h08, 2, 0, 32'h1234);
    imem[4]  = op_i(6'h2B, 2, 1, -4);
    imem[5]  = op_i(6'h23, 3, 1, -4);
    imem[8]  = op_i(6'h08, 4, 3, 1);
    imem[11] = op_i(6'h2B, 4, 1, 1);
    run(25);
    chk("R5", "store at base-4", dmem[16], 32'h1234);
    chk("R6", "loaded value reused", dmem[21], 32'h1235);
    chk("R5", "base word untouched", dmem[20], FILL);
    chk("R5", "one strobe per store", store_cnt, 2);
  endtask

  task automatic t_timing();
    clear_mems();
    imem[0] = op_i(6'h08, 1, 0, 7);
    imem[3] = op_r(6'h20, 2, 1, 1);
    imem[6] = op_i(6'h2B, 2, 0, 5);
    run(20);
    chk("R7", "consumer three slots later", dmem[5], 32'd14);
    chk("R7", "store cycle of instr 6", first_store, 9);
  endtask

  task automatic t_zero();
    clear_mems();
    imem[0] = op_i(6'h08, 0, 0, 7);
    imem[3] = op_r(6'h20, 1, 0, 0);
    imem[6] = op_i(6'h2B, 0, 0, 2);
    imem[7] = op_i(6'h2B, 1, 0, 3);
    run(20);
    chk("R8", "r0 after write", dmem[2], 32'd0);
    chk("R8", "r0 read during its write-back", dmem[3], 32'd0);
  endtask

  task automatic t_jump();
    clear_mems();
    imem[0] = op_i(6'h08, 1, 0, 9);
    imem[1] = op_j(6);
    imem[2] = op_i(6'h2B, 1, 0, 30);
    imem[3] = op_i(6'h2B, 1, 0, 31);
    imem[6] = op_i(6'h2B, 1, 0, 32);
    run(20);
    chk("R9", "fetch address after jump", addr_at[3], 32'd6);
    chk("R9", "slot behind jump discarded", dmem[30], FILL);
    chk("R9", "skipped instr not run", dmem[31], FILL);
    chk("R9", "target executed", dmem[32], 32'd9);
    chk("R9", "store count", store_cnt, 1);
  endtask

  task automatic t_unsupported();
    clear_mems();
    imem[0] = op_i(6'h08, 1, 0, 4);
    imem[3] = op_r(6'h00, 1, 1, 1);
    imem[4] = op_i(6'h3F, 1, 1, 100);
    imem[5] = op_r(6'h20, 1, 1, 1) | 32'h0000_0040;
    imem[8] = op_i(6'h2B, 1, 0, 40);
    run(20);
    chk("R10", "register unchanged", dmem[40], 32'd4);
    chk("R10", "no extra stores", store_cnt, 1);
  endtask

  initial begin
    clear_mems();
    t_reset();
    t_alu();
    t_mem();
    t_timing();
    t_zero();
    t_jump();
    t_unsupported();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule